// File: doc/BRIEF.md
# Monitor channel receive controller

This block takes the monitor byte of each frame on a time-division line interface, together with the two handshake bits of that frame: A, the acknowledge bit, and E, the end/valid bit. It places accepted bytes in a one-entry receive buffer that the host reads and then releases. A frame strobe marks the single cycle in which the frame's byte and bits are valid. The receive state changes only on that strobe. The one exception is the host release, which takes effect in any cycle.

A control input selects one of two modes. In transparent mode, every byte that arrives while the buffer is empty is stored together with the raw A and E bits of the same frame. A byte that arrives while the buffer is full is dropped. In monitor-protocol mode, the block runs the byte handshake itself:

- It accepts a byte when E goes active (low).
- It acknowledges the byte by driving its outgoing A bit low for one frame.
- It withholds that acknowledgement while the buffer is still full, which makes the far end repeat the byte.

A host command can abort the exchange. The block then holds A inactive for two frames and ignores incoming bytes during that time. An interrupt is raised while the buffer holds data, and a mask bit gates it.

The handshake state machine has five states:

| State | Meaning |
|---|---|
| S_IDLE | Waiting for E to fall. |
| S_WAIT | A byte was seen while the buffer was full; waiting for the buffer to free up. |
| S_ACK | A byte was stored; A is driven low for this frame. |
| S_ABT1 | First frame of an abort. |
| S_ABT2 | Second frame of an abort. |

Every transition happens on a strobe:

| Transition | Condition |
|---|---|
| IDLE/ACK→ACK | E falls and the buffer is free. The byte is stored. |
| IDLE/ACK→WAIT | E falls and the buffer is full. |
| IDLE/ACK→IDLE | E does not fall. |
| WAIT→ACK | E is still low and the buffer is now free. The byte is stored. |
| WAIT→IDLE | E has returned high. The byte is dropped. |
| WAIT→WAIT | E is still low and the buffer is still full. |
| any→ABT1 | Abort command in monitor-protocol mode. This has priority over every other transition. |
| ABT1→ABT2 | Always. |
| ABT2→IDLE | Always. |
| any→IDLE | Transparent mode is selected. |

Top module: `mon_rx_ctrl`

## Requirements
- R1: After reset, bd_full=0, irq=0, tx_a=1 and the handshake is idle.
- R2: mode_mon=0 selects transparent mode and mode_mon=1 selects monitor-protocol mode. The input is sampled at each strobe.
- R3: In transparent mode, a strobe that finds the buffer empty stores rx_byte, rx_a and rx_e into bd_byte, bd_a and bd_e, and sets bd_full. These values are visible in the cycle after the strobe.
- R4: In transparent mode, a strobe that finds bd_full=1 leaves bd_byte, bd_a and bd_e unchanged. The byte is discarded.
- R5: irq equals bd_full AND irq_en in every cycle. It stays high until host_ack, and it drops as soon as irq_en is cleared.
- R6: A host_ack pulse clears bd_full in the next cycle. If host_ack coincides with a strobe that finds bd_full=1, the byte of that strobe is discarded and the buffer is still freed.
- R7: In monitor-protocol mode, a byte is taken only at a strobe where rx_e=0 and rx_e was 1 at the previous strobe. A strobe where E stays low stores nothing.
- R8: After a monitor-mode store, tx_a is 0 from the storing strobe until the next strobe, and returns to 1 after that next strobe.
- R9: If E falls while the buffer is full, nothing is stored and tx_a stays 1. At a later strobe with the buffer free and rx_e still 0, the byte of that strobe is stored and acknowledged. If rx_e has returned to 1 first, the byte is dropped.
- R10: When abort_cmd=1 at a strobe in monitor-protocol mode, tx_a is held at 1 over the following two strobe intervals, overriding a pending acknowledgement. During those intervals, and at the strobe that ends them, no byte is stored. In transparent mode abort_cmd has no effect.
- R11: Between strobes, bd_byte, bd_a, bd_e and the handshake state do not change, whatever rx_byte, rx_a and rx_e do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_mon | input | 1 | 0 = transparent, 1 = monitor protocol |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| slot_stb | input | 1 | One-cycle strobe marking the frame's monitor slot |
| rx_byte | input | W | Received monitor byte |
| rx_a | input | 1 | Received A bit |
| rx_e | input | 1 | Received E bit, active low |
| abort_cmd | input | 1 | Abort request command, sampled at strobe |
| host_ack | input | 1 | Host releases the buffer |
| bd_byte | output | W | Buffered byte |
| bd_a | output | 1 | Buffered A bit |
| bd_e | output | 1 | Buffered E bit |
| bd_full | output | 1 | Buffer holds unread data |
| irq | output | 1 | Interrupt |
| tx_a | output | 1 | Outgoing A bit, 0 = acknowledge |

## Verification
The buffer outputs, the full flag and the handshake state are registered on the strobe edge. They are therefore due one cycle after the strobe cycle. irq and tx_a follow combinationally from those registers and from irq_en and mode_mon, so they are due in the same cycle as those registers or inputs. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. It compares every output 1 ns after each rising edge, so each result is checked in exactly the cycle it becomes due. Between strobes the bench scrambles the received byte and bits, so the every-cycle comparison also covers R11.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WAIT = 3'd1,
        S_ACK  = 3'd2,
        S_ABT1 = 3'd3,
        S_ABT2 = 3'd4
    } mon_state_t;
endpackage

// File: rtl/mon_e_edge.sv
module mon_e_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_stb,
    input  logic rx_e,
    output logic e_fall
);
    logic e_last;

    // E history is sampled only on the slot strobe; idle level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            e_last <= 1'b1;
        else if (slot_stb)
            e_last <= rx_e;
    end

    assign e_fall = slot_stb & e_last & ~rx_e;
endmodule

// File: rtl/mon_hs_fsm.sv
module mon_hs_fsm
    import mon_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_stb,
    input  logic       mode_mon,
    input  logic       abort_cmd,
    input  logic       e_fall,
    input  logic       rx_e,
    input  logic       buf_full,
    output logic       store_req,
    output logic       tx_a,
    output mon_state_t state_o
);
    mon_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt       = state;
        store_req = 1'b0;
        if (slot_stb) begin
            if (!mode_mon) begin
                nxt       = S_IDLE;
                store_req = ~buf_full;
            end else if (abort_cmd) begin
                nxt = S_ABT1;
            end else begin
                unique case (state)
                    S_IDLE, S_ACK: begin
                        if (e_fall) begin
                            if (!buf_full) begin
                                store_req = 1'b1;
                                nxt       = S_ACK;
                            end else begin
                                nxt = S_WAIT;
                            end
                        end else begin
                            nxt = S_IDLE;
                        end
                    end
                    S_WAIT: begin
                        if (rx_e) begin
                            nxt = S_IDLE;
                        end else if (!buf_full) begin
                            store_req = 1'b1;
                            nxt       = S_ACK;
                        end
                    end
                    S_ABT1:  nxt = S_ABT2;
                    S_ABT2:  nxt = S_IDLE;
                    default: nxt = S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        tx_a = 1'b1;
        if (mode_mon && state == S_ACK)
            tx_a = 1'b0;
    end

    assign state_o = state;

    // R11
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> $stable(state));

    // R10
    abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && mode_mon && abort_cmd) |=> (state == S_ABT1));

    // R8
    ack_one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && state == S_ACK) |=> (state != S_ACK));
endmodule

// File: rtl/mon_rx_bd.sv
module mon_rx_bd #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         store,
    input  logic         host_ack,
    input  logic         irq_en,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_a,
    input  logic         rx_e,
    output logic [W-1:0] bd_byte,
    output logic         bd_a,
    output logic         bd_e,
    output logic         bd_full,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bd_byte <= '0;
            bd_a    <= 1'b1;
            bd_e    <= 1'b1;
            bd_full <= 1'b0;
        end else if (store) begin
            bd_byte <= rx_byte;
            bd_a    <= rx_a;
            bd_e    <= rx_e;
            bd_full <= 1'b1;
        end else if (host_ack) begin
            bd_full <= 1'b0;
        end
    end

    assign irq = bd_full & irq_en;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> !bd_full);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !store) |=> !bd_full);
endmodule

// File: rtl/mon_rx_ctrl.sv
module mon_rx_ctrl
    import mon_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_mon,
    input  logic         irq_en,
    input  logic         slot_stb,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_a,
    input  logic         rx_e,
    input  logic         abort_cmd,
    input  logic         host_ack,
    output logic [W-1:0] bd_byte,
    output logic         bd_a,
    output logic         bd_e,
    output logic         bd_full,
    output logic         irq,
    output logic         tx_a
);
    logic       e_fall;
    logic       store_req;
    mon_state_t hs_state;

    mon_e_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_stb (slot_stb),
        .rx_e     (rx_e),
        .e_fall   (e_fall)
    );

    mon_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_stb  (slot_stb),
        .mode_mon  (mode_mon),
        .abort_cmd (abort_cmd),
        .e_fall    (e_fall),
        .rx_e      (rx_e),
        .buf_full  (bd_full),
        .store_req (store_req),
        .tx_a      (tx_a),
        .state_o   (hs_state)
    );

    mon_rx_bd #(.W(W)) u_bd (
        .clk      (clk),
        .rst_n    (rst_n),
        .store    (store_req),
        .host_ack (host_ack),
        .irq_en   (irq_en),
        .rx_byte  (rx_byte),
        .rx_a     (rx_a),
        .rx_e     (rx_e),
        .bd_byte  (bd_byte),
        .bd_a     (bd_a),
        .bd_e     (bd_e),
        .bd_full  (bd_full),
        .irq      (irq)
    );

    // R11
    bd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> ($stable(bd_byte) && $stable(bd_a) && $stable(bd_e)));

    // R4
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_full && !host_ack) |=> ($stable(bd_byte) && bd_full));

    // R3
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bd_full) |-> $past(slot_stb));

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_mon && (hs_state == S_ABT1 || hs_state == S_ABT2)) |-> (tx_a && !store_req));
endmodule

// File: tb/mon_rx_ctrl_tb.sv
module mon_rx_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_mon = 1'b0, irq_en = 1'b1, slot_stb = 1'b0;
    logic [W-1:0] rx_byte = '0;
    logic         rx_a = 1'b1, rx_e = 1'b1, abort_cmd = 1'b0, host_ack = 1'b0;
    logic [W-1:0] bd_byte;
    logic         bd_a, bd_e, bd_full, irq, tx_a;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_rx_ctrl #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_mon(mode_mon), .irq_en(irq_en),
        .slot_stb(slot_stb), .rx_byte(rx_byte), .rx_a(rx_a), .rx_e(rx_e),
        .abort_cmd(abort_cmd), .host_ack(host_ack), .bd_byte(bd_byte),
        .bd_a(bd_a), .bd_e(bd_e), .bd_full(bd_full), .irq(irq), .tx_a(tx_a)
    );

    // behavioural reference: 0 idle, 1 waiting, 2 acknowledging, 3/4 abort frames
    int           m_phase = 0;
    bit           m_full = 0, m_prev_e = 1, m_a = 1, m_e = 1;
    logic [W-1:0] m_byte = '0;

    always @(posedge clk) begin
        bit take;
        bit fell;
        take = 0;
        if (!rst_n) begin
            m_phase = 0; m_full = 0; m_prev_e = 1; m_a = 1; m_e = 1; m_byte = '0;
        end else begin
            if (slot_stb) begin
                fell = m_prev_e && !rx_e;
                m_prev_e = rx_e;
                if (!mode_mon) begin
                    m_phase = 0;
                    take = !m_full;
                end else if (abort_cmd) begin
                    m_phase = 3;
                end else if (m_phase == 0 || m_phase == 2) begin
                    if (fell) begin
                        if (!m_full) begin take = 1; m_phase = 2; end
                        else m_phase = 1;
                    end else m_phase = 0;
                end else if (m_phase == 1) begin
                    if (rx_e) m_phase = 0;
                    else if (!m_full) begin take = 1; m_phase = 2; end
                end else if (m_phase == 3) m_phase = 4;
                else m_phase = 0;
            end
            if (take) begin
                m_byte = rx_byte; m_a = rx_a; m_e = rx_e; m_full = 1;
            end else if (host_ack) m_full = 0;
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // compare every cycle, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(cur_req, "bd_full", bd_full, m_full);
            chk(cur_req, "bd_byte", bd_byte, m_byte);
            chk(cur_req, "bd_a", bd_a, m_a);
            chk(cur_req, "bd_e", bd_e, m_e);
            chk(cur_req, "irq", irq, m_full && irq_en);
            chk(cur_req, "tx_a", tx_a, !(mode_mon && m_phase == 2));
        end
    end

    task automatic frame(input logic [W-1:0] b, input logic a, input logic e,
                         input logic ab, input logic ack);
        @(negedge clk);
        rx_byte = b; rx_a = a; rx_e = e; abort_cmd = ab; host_ack = ack;
        slot_stb = 1'b1;
        @(negedge clk);
        slot_stb = 1'b0; abort_cmd = 1'b0; host_ack = 1'b0;
        rx_byte = ~b; rx_a = ~a; rx_e = ~e;
        @(negedge clk);
        rx_byte = b ^ 8'h5A; rx_e = e;
        @(negedge clk);
    endtask

    task automatic release_buf();
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "bd_full", bd_full, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "tx_a", tx_a, 1);

        // transparent mode
        cur_req = "R3";
        frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3", "stored byte", bd_byte, 8'h5A);
        chk("R3", "stored e", bd_e, 0);
        chk("R5", "irq raised", irq, 1);
        cur_req = "R4";
        frame(8'h33, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4", "byte kept", bd_byte, 8'h5A);
        cur_req = "R6";
        release_buf();
        @(negedge clk);
        chk("R6", "full cleared", bd_full, 0);
        chk("R5", "irq dropped", irq, 0);
        frame(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3", "stored a", bd_a, 0);
        cur_req = "R5";
        @(negedge clk); irq_en = 1'b0;
        @(negedge clk);
        chk("R5", "masked irq", irq, 0);
        irq_en = 1'b1;
        cur_req = "R6";
        frame(8'h99, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R6", "ack at strobe frees", bd_full, 0);
        chk("R6", "byte at busy strobe dropped", bd_byte, 8'hC3);
        cur_req = "R10";
        frame(8'h0F, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R10", "abort ignored transparent, stored", bd_byte, 8'h0F);
        chk("R10", "tx_a idle", tx_a, 1);
        release_buf();

        // monitor-protocol mode
        cur_req = "R2";
        @(negedge clk); mode_mon = 1'b1;
        frame(8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2", "no store on idle E", bd_full, 0);
        cur_req = "R7";
        frame(8'h11, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7", "stored on E fall", bd_byte, 8'h11);
        chk("R8", "ack driven", tx_a, 0);
        cur_req = "R8";
        frame(8'h11, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8", "ack released", tx_a, 1);
        release_buf();
        cur_req = "R7";
        frame(8'h22, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7", "E held low no store", bd_full, 0);
        frame(8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
        frame(8'h44, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7", "second byte", bd_byte, 8'h44);
        cur_req = "R9";
        frame(8'h44, 1'b1, 1'b1, 1'b0, 1'b0);
        frame(8'h55, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9", "withheld ack", tx_a, 1);
        chk("R9", "no store when full", bd_byte, 8'h44);
        frame(8'h55, 1'b1, 1'b0, 1'b0, 1'b0);
        release_buf();
        frame(8'h56, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9", "repeat stored", bd_byte, 8'h56);
        chk("R9", "late ack", tx_a, 0);
        frame(8'h56, 1'b1, 1'b1, 1'b0, 1'b0);
        frame(8'h66, 1'b1, 1'b0, 1'b0, 1'b0);
        frame(8'h66, 1'b1, 1'b1, 1'b0, 1'b0);
        release_buf();
        frame(8'h67, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R9", "withdrawn byte dropped", bd_full, 0);
        chk("R9", "old byte kept", bd_byte, 8'h56);

        // abort in monitor mode
        cur_req = "R10";
        frame(8'h77, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R10", "abort frame 1 no store", bd_full, 0);
        chk("R10", "abort frame 1 tx_a", tx_a, 1);
        frame(8'h77, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10", "abort frame 2 tx_a", tx_a, 1);
        frame(8'h78, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10", "byte at abort end dropped", bd_full, 0);
        frame(8'h78, 1'b1, 1'b1, 1'b0, 1'b0);
        frame(8'h79, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10", "store resumes", bd_byte, 8'h79);
        frame(8'h79, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R10", "abort overrides ack", tx_a, 1);
        cur_req = "R11";
        repeat (6) begin
            @(negedge clk); rx_byte = rx_byte + 8'h13; rx_e = ~rx_e; rx_a = ~rx_a;
        end
        chk("R11", "held between strobes", bd_byte, 8'h79);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule